// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is the host-facing register file of one bus-master DMA channel for a disk controller. It has three registers: a command register that starts and stops transfers, a status register that reports progress, errors and interrupts, and a 32-bit base address that points at the descriptor table in memory. The host reaches all three through a byte-addressed port with byte, halfword and word access sizes. Writes take effect on the clock edge. Reads are combinational from the stored values.

On the engine side, the block sends out a one-cycle start pulse, a one-cycle cancel pulse, the transfer direction, the active flag, the table base and a current-descriptor pointer. The pointer is reloaded from the base each time a start is requested. The engine reports the end of a run with a done strobe and a "more" flag, and reports faults with a one-cycle error strobe. A rising edge on the drive's interrupt line latches the interrupt status bit. The line itself is passed straight through to the host.

Top module: `busmaster_dma_regs`

## Requirements
- R1: A command write whose bit 0 (start) equals the stored start bit produces neither a start pulse nor a cancel pulse, and leaves the active bit as it was.
- R2: A command write that changes the start bit from 1 to 0 raises `eng_cancel` for one cycle, starting the cycle after the write, and clears the active bit (status bit 0) in that same cycle.
- R3: A command write that changes the start bit from 0 to 1 loads `desc_ptr` from the base address in the next cycle and sets the active bit. `eng_start` pulses for one cycle only if the active bit was clear before the write.
- R4: The command register sits at offset 0. From a command write it keeps bit 0 (start) and bit 3 (direction, driven on `eng_dir`), and every other bit reads back as 0.
- R5: The status register sits at offset 2. On a status write, bits 5 and 6 take the written value, bit 0 (active) is unchanged, and bits 1 (error) and 2 (interrupt) are cleared only where a 1 is written. Bits 3, 4 and 7 read as 0.
- R6: A 0-to-1 transition of `drive_irq` sets status bit 2 in the next cycle. `host_irq` follows `drive_irq` in the same cycle in both directions, and a falling level changes no status bit.
- R7: The base address occupies offsets 4 to 7, least significant byte first. `host_size` 0, 1 and 2 select byte, halfword and word. A write updates only the byte lanes from its offset up to the top of the register, and bits 1:0 always read as 0. A read returns the register shifted right by the offset's byte count and masked to the access size.
- R8: Reset clears command, status, base address, `desc_ptr`, the pulses and the edge-detect history.
- R9: An `eng_done` strobe sets the active bit to the value of `eng_more`. In the same cycle, a start or stop command takes priority over it.
- R10: An `eng_err` strobe sets status bit 1 in the next cycle. It wins over a same-cycle write-one-to-clear of that bit, and likewise a drive interrupt rise wins over a same-cycle clear of bit 2.
- R11: Offsets 1 and 3 are unmapped. Writes there change nothing, and reads there return all ones within the access size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Byte offset of the host access |
| host_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| host_wr | input | 1 | Write strobe for the current access |
| host_wdata | input | 32 | Write data, right-aligned |
| host_rdata | output | 32 | Read data for the addressed register, right-aligned |
| eng_start | output | 1 | One-cycle request to begin a transfer |
| eng_cancel | output | 1 | One-cycle request to abort a transfer |
| eng_dir | output | 1 | Direction bit from the command register |
| eng_active | output | 1 | Active bit of the status register |
| tbl_base | output | 32 | Descriptor table base address |
| desc_ptr | output | 32 | Current descriptor pointer |
| eng_done | input | 1 | Engine end-of-run strobe |
| eng_more | input | 1 | Keep active after done when 1 |
| eng_err | input | 1 | Engine error strobe |
| drive_irq | input | 1 | Drive interrupt level |
| host_irq | output | 1 | Interrupt level forwarded to the host |

## Verification
The bench rewrites the start bit with its current value. A design that acted on the written level rather than on a change would issue a spurious start or cancel. It sets the active bit through a done-with-more before a start, which exposes a design that always pulses start and would restart a running engine. It strikes a write-one-to-clear in the same cycle as a new error or interrupt rise, where the wrong priority silently loses an event. Partial base writes at every offset and size would show a lane-enable error as corrupted neighbouring bytes or nonzero low bits.

// File: rtl/bmdma_regs_pkg.sv
package bmdma_regs_pkg;

  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_CMD  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd2;

  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 3;
  localparam logic [7:0] CMD_KEEP = 8'h09;

  localparam int ST_ACT = 0;
  localparam int ST_ERR = 1;
  localparam int ST_IRQ = 2;
  localparam logic [7:0] ST_RW = 8'h60;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  function automatic int size_bytes(input acc_size_e sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return LANES;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input acc_size_e sz);
    case (sz)
      SZ_BYTE: return {{(DATA_W-8){1'b0}}, 8'hFF};
      SZ_HALF: return {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: return {DATA_W{1'b1}};
    endcase
  endfunction

  function automatic logic [LANES-1:0] lane_enables(input logic [1:0] off, input acc_size_e sz);
    logic [LANES-1:0] en;
    int o;
    int nb;
    o  = int'(off);
    nb = size_bytes(sz);
    for (int k = 0; k < LANES; k++) begin
      en[k] = (k >= o) && (k < o + nb);
    end
    return en;
  endfunction

  function automatic logic w1c_update(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/bmdma_cmd_unit.sv
module bmdma_cmd_unit
  import bmdma_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [7:0] wbyte,
  output logic       go_evt,
  output logic       stop_evt,
  output logic       dir_q,
  output logic       cancel_pulse,
  output logic [7:0] cmd_byte
);

  logic [7:0] cmd_q;
  logic       start_q;

  assign start_q  = cmd_q[CMD_GO];
  assign dir_q    = cmd_q[CMD_DIR];
  assign cmd_byte = cmd_q;

  assign go_evt   = wr_hit &&  wbyte[CMD_GO] && !start_q;
  assign stop_evt = wr_hit && !wbyte[CMD_GO] &&  start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q        <= '0;
      cancel_pulse <= 1'b0;
    end else begin
      cancel_pulse <= stop_evt;
      if (wr_hit) cmd_q <= wbyte & CMD_KEEP;
    end
  end

  // R2: a cancel pulse follows only a 1-to-0 change of the start bit
  assert_cancel_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_pulse |-> (!start_q && $past(start_q)));

  // R1: a write that keeps the start bit never yields a cancel
  assert_same_start_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && (wbyte[CMD_GO] == start_q)) |=> !cancel_pulse);

  // R4: only the start and direction bits survive
  assert_cmd_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (cmd_q == ($past(wbyte) & CMD_KEEP)));

endmodule

// File: rtl/bmdma_status_unit.sv
module bmdma_status_unit
  import bmdma_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_evt,
  input  logic       stop_evt,
  input  logic       wr_hit,
  input  logic [7:0] wbyte,
  input  logic       eng_done,
  input  logic       eng_more,
  input  logic       eng_err,
  input  logic       drive_irq,
  output logic       active_q,
  output logic       start_pulse,
  output logic [7:0] stat_byte
);

  logic       err_q;
  logic       irq_q;
  logic       irq_prev;
  logic [7:0] rw_q;
  logic       irq_rise;
  logic       act_next;
  logic       err_clr;
  logic       irq_clr;

  assign irq_rise = drive_irq && !irq_prev;
  assign err_clr  = wr_hit && wbyte[ST_ERR];
  assign irq_clr  = wr_hit && wbyte[ST_IRQ];

  always_comb begin
    if (stop_evt)      act_next = 1'b0;
    else if (go_evt)   act_next = 1'b1;
    else if (eng_done) act_next = eng_more;
    else               act_next = active_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      start_pulse <= 1'b0;
      err_q       <= 1'b0;
      irq_q       <= 1'b0;
      irq_prev    <= 1'b0;
      rw_q        <= '0;
    end else begin
      active_q    <= act_next;
      start_pulse <= go_evt && !active_q;
      err_q       <= w1c_update(err_q, err_clr, eng_err);
      irq_q       <= w1c_update(irq_q, irq_clr, irq_rise);
      irq_prev    <= drive_irq;
      if (wr_hit) rw_q <= wbyte & ST_RW;
    end
  end

  always_comb begin
    stat_byte         = rw_q;
    stat_byte[ST_ACT] = active_q;
    stat_byte[ST_ERR] = err_q;
    stat_byte[ST_IRQ] = irq_q;
  end

  // R3: a start pulse only when active was clear and is now set
  assert_start_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (active_q && !$past(active_q)));

  // R2: a stop leaves active clear
  assert_stop_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !active_q);

  // R9: done alone loads active from the more flag
  assert_done_more_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !go_evt && !stop_evt) |=> (active_q == $past(eng_more)));

  // R10: an error strobe always lands in the error bit
  assert_err_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> err_q);

  // R6: a rising drive interrupt always lands in the interrupt bit
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> irq_q);

  // R5: without a written 1 or new event the sticky bits hold
  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_clr && !eng_err) |=> (err_q == $past(err_q)));

endmodule

// File: rtl/bmdma_base_unit.sv
module bmdma_base_unit
  import bmdma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [1:0]        off,
  input  acc_size_e         sz,
  input  logic [DATA_W-1:0] wdata,
  input  logic              reload,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] ptr_q
);

  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] shifted;

  assign lane_we = wr_hit ? lane_enables(off, sz) : '0;
  assign shifted = wdata << {off, 3'b000};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam logic [7:0] KEEP = (k == 0) ? 8'hFC : 8'hFF;

    always_ff @(posedge clk) begin
      if (!rst_n)          base_q[k*8 +: 8] <= '0;
      else if (lane_we[k]) base_q[k*8 +: 8] <= shifted[k*8 +: 8] & KEEP;
    end

    // R7: lanes outside the access keep their value
    assert_lane_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_we[k] |=> $stable(base_q[k*8 +: 8]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (reload) ptr_q <= base_q;
  end

  // R3: the pointer picks up the base seen at the start request
  assert_ptr_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (ptr_q == $past(base_q)));

endmodule

// File: rtl/busmaster_dma_regs.sv
module busmaster_dma_regs
  import bmdma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  host_addr,
  input  logic [1:0]        host_size,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              eng_start,
  output logic              eng_cancel,
  output logic              eng_dir,
  output logic              eng_active,
  output logic [DATA_W-1:0] tbl_base,
  output logic [DATA_W-1:0] desc_ptr,
  input  logic              eng_done,
  input  logic              eng_more,
  input  logic              eng_err,
  input  logic              drive_irq,
  output logic              host_irq
);

  acc_size_e  sz;
  logic       cmd_hit;
  logic       stat_hit;
  logic       base_hit;
  logic       go_evt;
  logic       stop_evt;
  logic [7:0] cmd_byte;
  logic [7:0] stat_byte;

  assign sz       = acc_size_e'(host_size);
  assign cmd_hit  = host_wr && (host_addr == OFS_CMD);
  assign stat_hit = host_wr && (host_addr == OFS_STAT);
  assign base_hit = host_wr && host_addr[2];

  bmdma_cmd_unit u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_hit       (cmd_hit),
    .wbyte        (host_wdata[7:0]),
    .go_evt       (go_evt),
    .stop_evt     (stop_evt),
    .dir_q        (eng_dir),
    .cancel_pulse (eng_cancel),
    .cmd_byte     (cmd_byte)
  );

  bmdma_status_unit u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_evt      (go_evt),
    .stop_evt    (stop_evt),
    .wr_hit      (stat_hit),
    .wbyte       (host_wdata[7:0]),
    .eng_done    (eng_done),
    .eng_more    (eng_more),
    .eng_err     (eng_err),
    .drive_irq   (drive_irq),
    .active_q    (eng_active),
    .start_pulse (eng_start),
    .stat_byte   (stat_byte)
  );

  bmdma_base_unit u_base (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (base_hit),
    .off    (host_addr[1:0]),
    .sz     (sz),
    .wdata  (host_wdata),
    .reload (go_evt),
    .base_q (tbl_base),
    .ptr_q  (desc_ptr)
  );

  assign host_irq = drive_irq;

  always_comb begin
    case (host_addr)
      OFS_CMD:  host_rdata = {{(DATA_W-8){1'b0}}, cmd_byte};
      OFS_STAT: host_rdata = {{(DATA_W-8){1'b0}}, stat_byte};
      3'd4, 3'd5, 3'd6, 3'd7:
                host_rdata = (tbl_base >> {host_addr[1:0], 3'b000}) & size_mask(sz);
      default:  host_rdata = size_mask(sz);
    endcase
  end

  // R11: writes to unmapped offsets leave every register alone
  assert_unmapped_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && (host_addr == 3'd1 || host_addr == 3'd3) && !eng_done && !eng_err)
      |=> ($stable(cmd_byte) && $stable(tbl_base) && $stable(stat_byte[6:5])));

  // R2 and R3: start and cancel never fire together
  assert_pulses_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_start && eng_cancel));

endmodule

// File: tb/test_busmaster_dma_regs.sv
`timescale 1ns/1ps
module test_busmaster_dma_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        eng_start, eng_cancel, eng_dir, eng_active, host_irq;
  logic [31:0] tbl_base, desc_ptr;
  logic        eng_done = 1'b0, eng_more = 1'b0, eng_err = 1'b0, drive_irq = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [7:0]  m_cmd;
  logic        m_act, m_err, m_irq, m_prev;
  logic [1:0]  m_rw;
  logic [31:0] m_base, m_ptr;
  logic        e_start, e_cancel;

  always #4 clk = ~clk;

  busmaster_dma_regs i_busmaster_dma_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_size(host_size),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_start(eng_start), .eng_cancel(eng_cancel), .eng_dir(eng_dir),
    .eng_active(eng_active), .tbl_base(tbl_base), .desc_ptr(desc_ptr),
    .eng_done(eng_done), .eng_more(eng_more), .eng_err(eng_err),
    .drive_irq(drive_irq), .host_irq(host_irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] b_mask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [7:0] m_status();
    return {1'b0, m_rw, 2'b00, m_irq, m_err, m_act};
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a, input logic [1:0] sz);
    logic [31:0] t;
    if (a == 3'd0) return {24'h0, m_cmd};
    if (a == 3'd2) return {24'h0, m_status()};
    if (a >= 3'd4) begin
      t = m_base;
      for (int i = 4; i < int'(a); i++) t = {8'h00, t[31:8]};
      return t & b_mask(sz);
    end
    return b_mask(sz);
  endfunction

  function automatic string read_req(input logic [2:0] a);
    if (a == 3'd0) return "R4";
    if (a == 3'd2) return "R5";
    if (a >= 3'd4) return "R7";
    return "R11";
  endfunction

  task automatic model_reset();
    m_cmd = '0; m_act = 0; m_err = 0; m_irq = 0; m_prev = 0;
    m_rw = '0; m_base = '0; m_ptr = '0; e_start = 0; e_cancel = 0;
  endtask

  task automatic model_step(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                            input logic [31:0] d, input logic dn, input logic mr,
                            input logic er, input logic irq);
    logic rise, started, stopped;
    int nb, o;
    logic [31:0] t;
    rise = irq && !m_prev;
    m_prev = irq;
    e_start = 0; e_cancel = 0; started = 0; stopped = 0;
    if (wr && a == 3'd0) begin
      if (d[0] && !m_cmd[0]) begin
        started = 1; m_ptr = m_base;
        if (!m_act) e_start = 1;
      end else if (!d[0] && m_cmd[0]) begin
        stopped = 1; e_cancel = 1;
      end
      m_cmd = {4'h0, d[3], 2'b00, d[0]};
    end
    if (stopped) m_act = 0;
    else if (started) m_act = 1;
    else if (dn) m_act = mr;
    if (wr && a == 3'd2) begin
      m_rw = d[6:5];
      if (d[1]) m_err = 0;
      if (d[2]) m_irq = 0;
    end
    if (er) m_err = 1;
    if (rise) m_irq = 1;
    if (wr && a >= 3'd4) begin
      o = int'(a) - 4;
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      t = d;
      for (int k = 0; k < 4; k++) begin
        if (k >= o && k < o + nb) begin
          m_base[k*8 +: 8] = t[7:0];
          t = t >> 8;
        end
      end
      m_base[1:0] = 2'b00;
    end
  endtask

  task automatic do_cycle(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input logic dn, input logic mr,
                          input logic er, input logic irq,
                          input logic [2:0] ra, input logic [1:0] rs);
    @(negedge clk);
    host_wr = wr; host_addr = a; host_size = sz; host_wdata = d;
    eng_done = dn; eng_more = mr; eng_err = er; drive_irq = irq;
    model_step(wr, a, sz, d, dn, mr, er, irq);
    @(posedge clk);
    #1;
    chk("R3", "eng_start", {31'h0, eng_start}, {31'h0, e_start});
    chk("R2", "eng_cancel", {31'h0, eng_cancel}, {31'h0, e_cancel});
    chk("R9", "eng_active", {31'h0, eng_active}, {31'h0, m_act});
    chk("R4", "eng_dir", {31'h0, eng_dir}, {31'h0, m_cmd[3]});
    chk("R7", "tbl_base", tbl_base, m_base);
    chk("R3", "desc_ptr", desc_ptr, m_ptr);
    host_wr = 0; eng_done = 0; eng_err = 0;
    host_addr = ra; host_size = rs;
    #1;
    chk(read_req(ra), "host_rdata", host_rdata, m_read(ra, rs));
    chk("R6", "host_irq", {31'h0, host_irq}, {31'h0, drive_irq});
  endtask

  task automatic idle(input logic [2:0] ra);
    do_cycle(0, 3'd0, 2'd0, 32'h0, 0, 0, 0, drive_irq, ra, 2'd0);
  endtask

  initial begin : watchdog
    #1600000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = $urandom(32'd20240611);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R8: reset state
    chk("R8", "rdata cmd", host_rdata, 32'h0);
    chk("R8", "eng_active", {31'h0, eng_active}, 32'h0);
    chk("R8", "tbl_base", tbl_base, 32'h0);
    chk("R8", "desc_ptr", desc_ptr, 32'h0);

    // R7: byte writes to every lane, low bits forced
    do_cycle(1, 3'd4, 2'd0, 32'hFF, 0, 0, 0, 0, 3'd4, 2'd2);
    chk("R7", "low bits zero", tbl_base, 32'h0000_00FC);
    do_cycle(1, 3'd6, 2'd1, 32'hBEEF, 0, 0, 0, 0, 3'd6, 2'd1);
    do_cycle(1, 3'd5, 2'd0, 32'h5A, 0, 0, 0, 0, 3'd5, 2'd0);
    chk("R7", "partial lanes", tbl_base, 32'hBEEF_5AFC);
    do_cycle(1, 3'd7, 2'd2, 32'h1234_5612, 0, 0, 0, 0, 3'd4, 2'd2);
    chk("R7", "top lane only", tbl_base, 32'h12EF_5AFC);

    // R3: start from idle
    do_cycle(1, 3'd0, 2'd0, 32'hFF, 0, 0, 0, 0, 3'd0, 2'd0);
    chk("R3", "start pulse", {31'h0, eng_start}, 32'h1);
    chk("R4", "cmd keeps 0 and 3", host_rdata, 32'h09);
    chk("R3", "ptr from base", desc_ptr, 32'h12EF_5AFC);
    // R1: rewrite start=1
    do_cycle(1, 3'd0, 2'd0, 32'h01, 0, 0, 0, 0, 3'd2, 2'd0);
    chk("R1", "no start on same", {31'h0, eng_start}, 32'h0);
    chk("R1", "no cancel on same", {31'h0, eng_cancel}, 32'h0);
    // R2: stop
    do_cycle(1, 3'd0, 2'd0, 32'h00, 0, 0, 0, 0, 3'd2, 2'd0);
    chk("R2", "cancel pulse", {31'h0, eng_cancel}, 32'h1);
    chk("R2", "active cleared", {31'h0, eng_active}, 32'h0);
    // R1: rewrite start=0
    do_cycle(1, 3'd0, 2'd0, 32'h00, 0, 0, 0, 0, 3'd0, 2'd0);
    chk("R1", "no cancel on same 0", {31'h0, eng_cancel}, 32'h0);
    // R9: done with more sets active, then start must not pulse
    do_cycle(0, 3'd0, 2'd0, 32'h0, 1, 1, 0, 0, 3'd2, 2'd0);
    chk("R9", "done more keeps active", {31'h0, eng_active}, 32'h1);
    do_cycle(1, 3'd0, 2'd0, 32'h01, 0, 0, 0, 0, 3'd2, 2'd0);
    chk("R3", "no start when active", {31'h0, eng_start}, 32'h0);
    do_cycle(0, 3'd0, 2'd0, 32'h0, 1, 0, 0, 0, 3'd2, 2'd0);
    chk("R9", "done without more", {31'h0, eng_active}, 32'h0);

    // R10: error strobe and W1C in the same cycle
    do_cycle(1, 3'd2, 2'd0, 32'h06, 0, 0, 1, 1, 3'd2, 2'd0);
    chk("R10", "set beats clear", host_rdata & 32'h6, 32'h6);
    do_cycle(1, 3'd2, 2'd0, 32'h66, 0, 0, 0, 1, 3'd2, 2'd0);
    chk("R5", "w1c and rw bits", host_rdata, 32'h60);
    // R6: falling irq leaves status
    do_cycle(0, 3'd0, 2'd0, 32'h0, 0, 0, 0, 0, 3'd2, 2'd0);
    chk("R6", "fall no status", host_rdata, 32'h60);
    // R11: unmapped offsets
    do_cycle(1, 3'd1, 2'd0, 32'hFF, 0, 0, 0, 0, 3'd3, 2'd1);
    chk("R11", "unmapped read", host_rdata, 32'h0000_FFFF);

    // random phase
    for (int it = 0; it < 3000; it++) begin
      logic [2:0] a;
      logic [31:0] d;
      logic [1:0] sz;
      int op;
      op = $urandom_range(0, 5);
      a = 3'($urandom_range(0, 7));
      sz = 2'($urandom_range(0, 2));
      d = $urandom();
      case (op)
        0: do_cycle(1, 3'd0, sz, d, $urandom_range(0, 1) == 0, d[9], 0, drive_irq,
                    3'($urandom_range(0, 7)), 2'($urandom_range(0, 2)));
        1: do_cycle(1, 3'd2, sz, d, 0, 0, $urandom_range(0, 3) == 0, d[12],
                    3'd2, 2'd0);
        2: do_cycle(1, a, sz, d, 0, 0, 0, drive_irq, a, sz);
        3: do_cycle(0, 3'd0, 2'd0, 32'h0, 1, d[0], d[1], d[2],
                    3'($urandom_range(0, 7)), sz);
        4: do_cycle(0, 3'd0, 2'd0, 32'h0, 0, 0, 0, ~drive_irq, 3'd2, 2'd0);
        default: do_cycle(1, a, sz, d, d[4], d[5], d[6], d[7],
                          3'($urandom_range(0, 7)), 2'($urandom_range(0, 2)));
      endcase
    end

    // R8: mid-run reset clears everything
    do_cycle(1, 3'd4, 2'd2, 32'hA5A5_A5A5, 0, 0, 0, 0, 3'd4, 2'd2);
    @(negedge clk);
    drive_irq = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    #1;
    host_addr = 3'd2;
    #1;
    chk("R8", "status after reset", host_rdata, 32'h0);
    chk("R8", "base after reset", tbl_base, 32'h0);
    chk("R8", "ptr after reset", desc_ptr, 32'h0);
    chk("R8", "dir after reset", {31'h0, eng_dir}, 32'h0);
    idle(3'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule